// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an incoming Ethernet frame as a byte stream and stores it in memory. Software provides a ring of descriptors. Each descriptor is two 32-bit words: an address word, then a status word. Each descriptor points at a 128-byte receive buffer.

Before it stores bytes, the engine reads the address word of the current descriptor. Bit 0 of that word is the ownership flag. A clear bit means the buffer belongs to the hardware.

- **Filling buffers:** bytes are packed little-endian into 32-bit words and written straight into the buffer. A frame longer than one buffer continues in the next descriptor.
- **Closing a buffer:** the engine writes the status word with the start flag, the end flag, the length and the filter flags. It then writes the address word back with the ownership bit set.
- **Wrap:** bit 1 of the address word marks the last descriptor of the ring. After that descriptor, the pointer returns to the programmed ring base.

Frames arrive with start, end and valid markers. Match flags from an address filter come with the last byte of each frame. The engine holds back the stream with `in_ready` while it reads a descriptor. The engine stops at the next frame boundary when reception is disabled. Writing the ring base moves the pointer back to the start of the ring.

If the descriptor needed in the middle of a frame is still owned by software, the engine drops the rest of that frame and raises a one-cycle overrun pulse. When no free descriptor is available at a frame boundary, the engine keeps polling the same descriptor, and `in_ready` stays low until software hands it back.

Top module: `rx_ring_writer`

## Requirements
- R1: Frame bytes are stored little-endian (byte n of a word in bits 8n+7:8n) at the buffer address taken from the address word with bits 1:0 cleared.
- R2: Before using a descriptor, the engine reads its address word and uses it only when bit 0 is clear.
- R3: When a buffer is closed, its address word is written back unchanged except that bit 0 is set to 1.
- R4: The status word has bit 14 set only in the buffer holding the first byte of a frame and bit 15 set only in the buffer holding its last byte. Bits 11:0 hold the total frame length in the last buffer and are zero in every other buffer.
- R5: In the last buffer of a frame, match flags `in_match[4:0]` appear in status bits 26:22 (`in_match[4]` is filter 1 at bit 26, `in_match[0]` is the type match at bit 22), and `in_match[5]` (broadcast) appears in bit 31. All other status bits are zero.
- R6: A buffer holds exactly 128 bytes. A frame of 128 bytes uses one descriptor, and a longer frame continues in the following descriptors.
- R7: After a descriptor whose address word has bit 1 set, the next descriptor is at the ring base. Otherwise it is 8 bytes further on.
- R8: If the next descriptor is already owned by software in the middle of a frame, `overrun` pulses for exactly one cycle and the rest of the frame is discarded with no memory write. The pointer stays on that descriptor, and the next frame is stored there once software releases it.
- R9: Clearing `rx_en` lets a frame already in progress complete. Frames offered while the engine is disabled are accepted and discarded with no memory access, and the descriptor pointer is not advanced.
- R10: Pulsing `base_wr` loads `ring_base` (the descriptor address divided by 8) and returns the pointer to it. The cycle after the pulse makes no memory access.
- R11: Bytes arriving outside a frame, meaning before any byte marked with `in_sof`, are discarded and write nothing.
- R12: `in_ready` is low in every cycle that issues a descriptor read, and every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| base_wr | input | 1 | Load pulse for the ring base |
| ring_base | input | 29 | Descriptor ring base address, bits 31:3 |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_match | input | 6 | Filter flags, sampled with the last byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| overrun | output | 1 | One-cycle pulse when a frame is cut short |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
A wrong pointer or wrap decision shows up within a few cycles of the closing write: the next frame's descriptor writes land at an address other than the expected ring slot. A stale byte lane or a wrong buffer counter corrupts the stored data or the length field, and this is visible when the closed buffer is read back. A wrong ownership decision shows either as an overrun pulse that appears or goes missing in the cycles right after the descriptor read, or as a frame that lands in a buffer software still owns.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        base_wr,
  input  logic [28:0] ring_base,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic [5:0]  in_match,
  output logic        in_ready,
  output logic        overrun,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int CNT_W = $clog2(BUF_BYTES);
  localparam int LEN_W = 12;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RECV, S_STAT, S_MARK, S_DROP} st_t;

  st_t              st;
  logic [28:0]      base_q, ptr;
  logic [29:0]      buf_q;
  logic             wrap_q, in_frame, first_q, last_q, ovr_q;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] flen;
  logic [31:0]      acc;
  logic [5:0]       flags_q;

  assign in_ready = (st == S_IDLE) || (st == S_RECV) || (st == S_DROP);
  assign overrun  = ovr_q;

  wire        byte_in   = in_valid && in_ready;
  wire        take      = (st == S_RECV) && byte_in && (in_frame || (in_sof && rx_en));
  wire [1:0]  lane      = cnt[1:0];
  wire        word_done = take && ((lane == 2'd3) || in_eof);
  wire [31:0] packed_w  = acc | (32'(in_data) << {lane, 3'b000});
  wire [28:0] ptr_nxt   = wrap_q ? base_q : 29'(ptr + 29'd1);
  wire [31:0] status_w  = {last_q & flags_q[5], 4'b0, last_q ? flags_q[4:0] : 5'b0, 6'b0,
                           last_q, first_q, 2'b0, last_q ? flen : {LEN_W{1'b0}}};

  assign mem_en = (st == S_FETCH) || (st == S_STAT) || (st == S_MARK) || word_done;
  assign mem_we = (st == S_STAT) || (st == S_MARK) || word_done;

  always_comb begin
    case (st)
      S_FETCH, S_MARK: mem_addr = {ptr, 3'b000};
      S_STAT:          mem_addr = {ptr, 3'b100};
      default:         mem_addr = {buf_q, 2'b00} + 32'({cnt[CNT_W-1:2], 2'b00});
    endcase
    case (st)
      S_STAT:  mem_wdata = status_w;
      S_MARK:  mem_wdata = {buf_q, wrap_q, 1'b1};
      default: mem_wdata = packed_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      ptr      <= '0;
      buf_q    <= '0;
      wrap_q   <= 1'b0;
      in_frame <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      ovr_q    <= 1'b0;
      cnt      <= '0;
      flen     <= '0;
      acc      <= '0;
      flags_q  <= '0;
    end else begin
      ovr_q <= 1'b0;
      case (st)
        S_IDLE:  if (rx_en) st <= S_FETCH;
        S_FETCH: st <= S_CHECK;
        S_CHECK: begin
          if (mem_rdata[0]) begin
            if (in_frame) begin
              ovr_q <= 1'b1;
              st    <= S_DROP;
            end else begin
              st <= rx_en ? S_FETCH : S_IDLE;
            end
          end else begin
            buf_q  <= mem_rdata[31:2];
            wrap_q <= mem_rdata[1];
            cnt    <= '0;
            acc    <= '0;
            st     <= S_RECV;
          end
        end
        S_RECV: begin
          if (take) begin
            if (!in_frame) begin
              in_frame <= 1'b1;
              first_q  <= 1'b1;
            end
            flen <= (in_frame ? flen : {LEN_W{1'b0}}) + 1'b1;
            cnt  <= cnt + 1'b1;
            acc  <= word_done ? 32'd0 : packed_w;
            if (in_eof) begin
              last_q  <= 1'b1;
              flags_q <= in_match;
              st      <= S_STAT;
            end else if (&cnt) begin
              st <= S_STAT;
            end
          end else if (!in_frame && !rx_en) begin
            st <= S_IDLE;
          end
        end
        S_STAT: st <= S_MARK;
        S_MARK: begin
          ptr     <= ptr_nxt;
          first_q <= 1'b0;
          last_q  <= 1'b0;
          if (last_q) begin
            in_frame <= 1'b0;
            st       <= rx_en ? S_FETCH : S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        S_DROP: begin
          if (byte_in && in_eof) begin
            in_frame <= 1'b0;
            st       <= rx_en ? S_FETCH : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (base_wr) begin
        base_q   <= ring_base;
        ptr      <= ring_base;
        in_frame <= 1'b0;
        st       <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_wr,
  input logic        in_ready,
  input logic        overrun,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_addr
);
  AST_OVR_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) overrun |=> !overrun); // R8
  AST_OVR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> !mem_we); // R8
  AST_BASE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) base_wr |=> !mem_en); // R10
  AST_READ_STALLS:  assert property (@(posedge clk) disable iff (!rst_n) (mem_en && !mem_we) |-> !in_ready); // R12
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> (mem_addr[1:0] == 2'b00)); // R12
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (.*);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 4;
  localparam int BUFB = 128;

  logic        clk = 1'b0;
  logic        rst_n, rx_en, base_wr;
  logic [28:0] ring_base;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic [5:0]  in_match;
  logic        in_ready, overrun, mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0, ovr_cnt = 0, mem_cnt = 0, exp_idx = 0;
  logic [31:0] mem [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer u_rx_ring_writer (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
    if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;
    if (rst_n && mem_en)  mem_cnt <= mem_cnt + 1;
  end

  function automatic logic [31:0] orig(int i);
    return 32'h400 + 32'(i * BUFB) + ((i == RING - 1) ? 32'd2 : 32'd0);
  endfunction

  function automatic logic [7:0] exp_byte(logic [7:0] tag, int k);
    return 8'(tag + 8'(k * 37));
  endfunction

  function automatic logic [31:0] exp_status(bit first, bit last, int len, logic [5:0] fl);
    logic [31:0] s = 32'd0;
    if (first) s[14] = 1'b1;
    if (last) begin
      s[15] = 1'b1;
      s[11:0] = 12'(len);
      s[26:22] = fl[4:0];
      s[31] = fl[5];
    end
    return s;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int len, logic [5:0] fl, logic [7:0] tag, int drop_at, bit sof_on);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if ($urandom % 5 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof   = sof_on && (k == 0);
      in_eof   = (k == len - 1);
      in_data  = exp_byte(tag, k);
      in_match = fl;
      if (k == drop_at) rx_en = 1'b0;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic check_frame(int start, int len, logic [5:0] fl, logic [7:0] tag,
                             int nb, bit ended, string req);
    for (int b = 0; b < nb; b++) begin
      int idx = (start + b) % RING;
      int errs = 0;
      logic [31:0] ba = orig(idx) & ~32'd3;
      chk(mem[idx*2] == (orig(idx) | 32'd1), "R3", mem[idx*2], orig(idx) | 32'd1);
      chk(mem[idx*2+1] == exp_status(b == 0, ended && (b == nb - 1), len, fl), req,
          mem[idx*2+1], exp_status(b == 0, ended && (b == nb - 1), len, fl));
      for (int j = 0; j < BUFB; j++) begin
        int k = b * BUFB + j;
        logic [31:0] w = mem[ba[11:2] + 10'(j / 4)];
        if (k < len && w[8*(j%4) +: 8] != exp_byte(tag, k)) errs++;
      end
      chk(errs == 0, "R1", 32'(errs), 32'd0);
      mem[idx*2]   = orig(idx);
      mem[idx*2+1] = 32'd0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap, nb, len;
    logic [5:0] fl;
    logic [7:0] tag;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int i = 0; i < RING; i++) mem[i*2] = orig(i);
    rst_n = 1'b0; rx_en = 1'b0; base_wr = 1'b0; ring_base = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0; in_match = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    // Reset state and idle engine (R9, R8)
    chk(overrun == 1'b0, "R8", 32'(overrun), 32'd0);
    chk(mem_cnt == 0, "R9", 32'(mem_cnt), 32'd0);
    chk(in_ready == 1'b1, "R9", 32'(in_ready), 32'd1);

    // R10: program ring base
    ring_base = 29'd0; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
    rx_en = 1'b1;
    wait_n(4);

    // R4 R5: short single-buffer frame with flags; first fetch must be R2
    send(60, 6'b100001, 8'h11, -1, 1'b1); wait_n(6);
    check_frame(0, 60, 6'b100001, 8'h11, 1, 1'b1, "R5");
    // R6: exactly one full buffer
    send(128, 6'b010000, 8'h22, -1, 1'b1); wait_n(6);
    check_frame(1, 128, 6'b010000, 8'h22, 1, 1'b1, "R6");
    // R6 R7: 129 bytes into slots 2 and 3, then wrap to slot 0
    send(129, 6'b000110, 8'h33, -1, 1'b1); wait_n(6);
    check_frame(2, 129, 6'b000110, 8'h33, 2, 1'b1, "R6");
    // R11: bytes without start marker are discarded
    send(20, 6'b0, 8'h44, -1, 1'b0); wait_n(6);
    chk(mem[0] == orig(0), "R11", mem[0], orig(0));
    send(10, 6'b001000, 8'h55, -1, 1'b1); wait_n(6);
    check_frame(0, 10, 6'b001000, 8'h55, 1, 1'b1, "R7");
    // R9: disable mid-frame, frame completes in slots 1 and 2
    send(200, 6'b000001, 8'h66, 50, 1'b1); wait_n(8);
    check_frame(1, 200, 6'b000001, 8'h66, 2, 1'b1, "R9");
    snap = mem_cnt;
    send(40, 6'b0, 8'h77, -1, 1'b1); wait_n(6);
    chk(mem_cnt == snap, "R9", 32'(mem_cnt), 32'(snap));
    chk(mem[6] == orig(3), "R9", mem[6], orig(3));
    rx_en = 1'b1; wait_n(4);
    send(30, 6'b000010, 8'h88, -1, 1'b1); wait_n(6);
    check_frame(3, 30, 6'b000010, 8'h88, 1, 1'b1, "R9");
    // R8: slot 2 owned by software, frame of 300 overruns after slots 0 and 1
    mem[4] = orig(2) | 32'd1;
    snap = ovr_cnt;
    send(300, 6'b100000, 8'h99, -1, 1'b1); wait_n(10);
    chk(ovr_cnt == snap + 1, "R8", 32'(ovr_cnt), 32'(snap + 1));
    chk(mem[5] == 32'd0, "R8", mem[5], 32'd0);
    check_frame(0, 300, 6'b100000, 8'h99, 2, 1'b0, "R8");
    mem[4] = orig(2);
    send(50, 6'b011111, 8'hAA, -1, 1'b1); wait_n(6);
    check_frame(2, 50, 6'b011111, 8'hAA, 1, 1'b1, "R8");
    // R10: base rewrite while pointer sits at slot 3
    snap = mem_cnt;
    base_wr = 1'b1; ring_base = 29'd0;
    @(negedge clk); base_wr = 1'b0;
    chk(mem_cnt == snap, "R10", 32'(mem_cnt), 32'(snap));
    wait_n(4);
    send(25, 6'b000100, 8'hBB, -1, 1'b1); wait_n(6);
    check_frame(0, 25, 6'b000100, 8'hBB, 1, 1'b1, "R10");
    exp_idx = 1;
    // R2 R6 R7: random frames wrapping the ring
    for (int n = 0; n < 40; n++) begin
      len = 1 + int'($urandom % 400);
      fl  = 6'($urandom);
      tag = 8'($urandom);
      nb  = (len + BUFB - 1) / BUFB;
      send(len, fl, tag, -1, 1'b1); wait_n(6);
      check_frame(exp_idx, len, fl, tag, nb, 1'b1, "R2");
      exp_idx = (exp_idx + nb) % RING;
    end
    chk(ovr_cnt == snap - snap + 1, "R8", 32'(ovr_cnt), 32'd1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule